// File: doc/BRIEF.md
# Legacy Configuration Port Pair with Reset Control Byte

This block is a slave on a simple I/O bus with a dword address and four byte enables. It provides the two-port mechanism that software uses to reach configuration space. A full 32-bit write to the address port stores a selector made of an enable flag, a bus number, a device number, a function number and a register dword index. Accesses to the data port are then passed to a downstream configuration-access interface, together with the fields of that stored selector.

A one-byte reset control register sits at the port one byte above the address port, inside the address register's dword. A single-byte access to that port always goes to the reset register and never touches the address selector. A write with the reset-trigger bit set sends a one-cycle system reset request and leaves the stored contents alone. Any other write keeps only the reset-type bit, which software can read back but which has no effect on the request.

Every bus request is handled in the cycle it is presented. Read data and its valid strobe appear one cycle later. The downstream configuration interface is combinational in the request cycle.

Top module: `cfg_port_reset_ctl`

## Requirements
- R1: After reset, the stored selector and the reset control byte are zero, `sys_rst_req` and `io_rvalid` are low, and reads of both ports return zero.
- R2: A write to the address port (dword 0x33E, port 0xCF8) with all four byte enables set stores the selector. A later read there returns the written value with bits 1:0 forced to zero.
- R3: An access to dword 0x33E with only byte enable 1 set (port 0xCF9) goes to the reset register and leaves the stored selector unchanged.
- R4: A write to port 0xCF9 whose byte has bit 2 set (io_wdata[10]) raises `sys_rst_req` for exactly the one cycle after the write and leaves the stored reset byte unchanged. Reads never raise it.
- R5: A write to port 0xCF9 with bit 2 clear stores only bit 1 of the byte (io_wdata[9]). A read returns that bit in io_rdata[9], with every other bit zero.
- R6: When selector bit 31 is set, an access to the data port (dword 0x33F, port 0xCFC) with any byte enable set raises `cfg_req` in the same cycle. It also drives `cfg_we`, `cfg_be` and `cfg_wdata` from the request, and bus (bits 23:16), device (15:11), function (10:8) and dword index (7:2) from the selector. A read returns `cfg_rdata` on the next cycle with `io_rvalid` high.
- R7: When selector bit 31 is clear, data-port accesses do not raise `cfg_req`: writes are dropped and reads return 0xFFFFFFFF.
- R8: Any other access is ignored: partial byte enables at dword 0x33E other than the single 0xCF9 byte, and any other dword. Reads of such accesses return 0xFFFFFFFF with `io_rvalid` high, and writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Bus request valid |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_dwaddr | input | 14 | Dword address (port address bits 15:2) |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_rvalid | output | 1 | Read data valid, one cycle after a read request |
| io_rdata | output | 32 | Read data |
| cfg_req | output | 1 | Downstream configuration access request |
| cfg_we | output | 1 | Downstream write |
| cfg_bus | output | 8 | Selected bus number |
| cfg_dev | output | 5 | Selected device number |
| cfg_func | output | 3 | Selected function number |
| cfg_dword | output | 6 | Selected register dword index |
| cfg_be | output | 4 | Downstream byte enables |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_rdata | input | 32 | Downstream read data, valid in the request cycle |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `io_req` stays low while reset is asserted, so the first cycle after reset has no prior request to look back at. They also assume that `io_wdata` is known whenever a write is presented, because the reset-trigger and selector-enable properties sample it through `$past`. The stimulus drives every input to a fixed value on the falling edge and holds `io_req` low through both reset phases. Idle cycles separate the requests, so each pulse and each read response can be tied to a single access.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

   typedef struct packed {
      logic       en;
      logic [6:0] rsvd;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [5:0] dw;
      logic [1:0] lo;
   } cfg_sel_t;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_ADDR = 2'd1,
      HIT_RST  = 2'd2,
      HIT_DATA = 2'd3
   } hit_e;

endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
   import cpr_pkg::*;
#(
   parameter int DW_W      = 14,
   parameter int ADDR_PORT = 'hCF8,
   parameter int DATA_PORT = 'hCFC,
   parameter int RST_PORT  = 'hCF9
) (
   input  logic            req,
   input  logic [DW_W-1:0] dwaddr,
   input  logic [3:0]      be,
   output hit_e            hit
);
   localparam logic [DW_W-1:0] ADDR_DW = DW_W'(ADDR_PORT / 4);
   localparam logic [DW_W-1:0] DATA_DW = DW_W'(DATA_PORT / 4);
   localparam logic [DW_W-1:0] RST_DW  = DW_W'(RST_PORT / 4);
   localparam logic [3:0]      RST_BE  = 4'b0001 << (RST_PORT % 4);

   // The reset byte is checked first: it outranks the address register.
   always_comb begin
      hit = HIT_NONE;
      if (req) begin
         if (dwaddr == RST_DW && be == RST_BE)
            hit = HIT_RST;
         else if (dwaddr == ADDR_DW && be == 4'hF)
            hit = HIT_ADDR;
         else if (dwaddr == DATA_DW && be != 4'h0)
            hit = HIT_DATA;
      end
   end
endmodule

// File: rtl/cpr_addr_reg.sv
module cpr_addr_reg
   import cpr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output cfg_sel_t    sel_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_en)
         sel_q <= cfg_sel_t'({wdata[31:2], 2'b00});
   end

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sel_q)); // R3
endmodule

// File: rtl/cpr_rst_reg.sv
module cpr_rst_reg #(
   parameter int TYPE_BIT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       trig_in,
   input  logic       type_in,
   output logic [7:0] rd_byte,
   output logic       rst_req
);
   logic type_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q  <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= wr_en && trig_in;
         if (wr_en && !trig_in)
            type_q <= type_in;
      end
   end

   assign rd_byte = 8'(type_q) << TYPE_BIT;

   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(wr_en && trig_in)); // R4
   AST_TYPE_HOLD_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && trig_in) |=> $stable(type_q)); // R4
   AST_TYPE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(type_q)); // R5
endmodule

// File: rtl/cfg_port_reset_ctl.sv
module cfg_port_reset_ctl
   import cpr_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int ADDR_PORT    = 'hCF8,
   parameter int DATA_PORT    = 'hCFC,
   parameter int RST_PORT     = 'hCF9,
   parameter int RST_TRIG_BIT = 2,
   parameter int RST_TYPE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              io_wr,
   input  logic [ADDR_W-3:0] io_dwaddr,
   input  logic [3:0]        io_be,
   input  logic [31:0]       io_wdata,
   output logic              io_rvalid,
   output logic [31:0]       io_rdata,
   output logic              cfg_req,
   output logic              cfg_we,
   output logic [7:0]        cfg_bus,
   output logic [4:0]        cfg_dev,
   output logic [2:0]        cfg_func,
   output logic [5:0]        cfg_dword,
   output logic [3:0]        cfg_be,
   output logic [31:0]       cfg_wdata,
   input  logic [31:0]       cfg_rdata,
   output logic              sys_rst_req
);
   localparam int DW_W     = ADDR_W - 2;
   localparam int RST_LANE = RST_PORT % 4;
   localparam int TRIG_POS = 8 * RST_LANE + RST_TRIG_BIT;
   localparam int TYPE_POS = 8 * RST_LANE + RST_TYPE_BIT;

   generate
      if (ADDR_PORT % 4 != 0) begin : g_chk_addr
         $error("address port must be dword aligned");
      end
      if (DATA_PORT % 4 != 0) begin : g_chk_data
         $error("data port must be dword aligned");
      end
      if (ADDR_PORT == DATA_PORT) begin : g_chk_same
         $error("address and data ports must differ");
      end
      if (RST_TRIG_BIT == RST_TYPE_BIT || RST_TRIG_BIT > 7 || RST_TYPE_BIT > 7) begin : g_chk_bits
         $error("reset bit positions invalid");
      end
      if (ADDR_W < 4 || DATA_PORT >= (1 << ADDR_W) || ADDR_PORT >= (1 << ADDR_W)) begin : g_chk_w
         $error("port outside address space");
      end
   endgenerate

   hit_e       hit;
   cfg_sel_t   sel_q;
   logic [7:0] rst_byte;
   logic [31:0] rst_word;
   logic       addr_wr;
   logic       rst_wr;
   logic       rvalid_q;
   logic [31:0] rdata_q;
   logic [31:0] rd_mux;

   cpr_decode #(
      .DW_W     (DW_W),
      .ADDR_PORT(ADDR_PORT),
      .DATA_PORT(DATA_PORT),
      .RST_PORT (RST_PORT)
   ) u_decode (
      .req   (io_req),
      .dwaddr(io_dwaddr),
      .be    (io_be),
      .hit   (hit)
   );

   assign addr_wr = (hit == HIT_ADDR) && io_wr;
   assign rst_wr  = (hit == HIT_RST) && io_wr;

   cpr_addr_reg u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(addr_wr),
      .wdata(io_wdata),
      .sel_q(sel_q)
   );

   cpr_rst_reg #(
      .TYPE_BIT(RST_TYPE_BIT)
   ) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (rst_wr),
      .trig_in(io_wdata[TRIG_POS]),
      .type_in(io_wdata[TYPE_POS]),
      .rd_byte(rst_byte),
      .rst_req(sys_rst_req)
   );

   // Place the reset byte in its own lane of the read word.
   for (genvar l = 0; l < 4; l++) begin : g_lane
      if (l == RST_LANE) begin : g_rst
         assign rst_word[8*l +: 8] = rst_byte;
      end else begin : g_zero
         assign rst_word[8*l +: 8] = 8'h00;
      end
   end

   assign cfg_req   = (hit == HIT_DATA) && sel_q.en;
   assign cfg_we    = io_wr;
   assign cfg_bus   = sel_q.bus;
   assign cfg_dev   = sel_q.dev;
   assign cfg_func  = sel_q.fn;
   assign cfg_dword = sel_q.dw;
   assign cfg_be    = io_be;
   assign cfg_wdata = io_wdata;

   always_comb begin
      unique case (hit)
         HIT_ADDR: rd_mux = sel_q;
         HIT_RST:  rd_mux = rst_word;
         HIT_DATA: rd_mux = sel_q.en ? cfg_rdata : 32'hFFFF_FFFF;
         default:  rd_mux = 32'hFFFF_FFFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= io_req && !io_wr;
         if (io_req && !io_wr)
            rdata_q <= rd_mux;
      end
   end

   assign io_rvalid = rvalid_q;
   assign io_rdata  = rdata_q;

   AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      io_rvalid |-> $past(io_req && !io_wr)); // R6
   AST_OFF_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(addr_wr && !io_wdata[31]) && !addr_wr) |-> !cfg_req); // R7
   AST_RST_HIT_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_RST) |-> ($countones(io_be) == 1)); // R3
   AST_RST_NO_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_wr) |=> !sys_rst_req); // R4
endmodule

// File: tb/cfg_port_reset_ctl_bench.sv
`timescale 1ns/1ps
module cfg_port_reset_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0;
   logic        io_wr = 1'b0;
   logic [13:0] io_dwaddr = '0;
   logic [3:0]  io_be = '0;
   logic [31:0] io_wdata = '0;
   logic        io_rvalid;
   logic [31:0] io_rdata;
   logic        cfg_req, cfg_we;
   logic [7:0]  cfg_bus;
   logic [4:0]  cfg_dev;
   logic [2:0]  cfg_func;
   logic [5:0]  cfg_dword;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        sys_rst_req;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [31:0] m_sel = '0;
   logic        m_type = 1'b0;
   logic        pend_rst = 1'b0;
   logic        exp_rst = 1'b0;

   always #2.5 clk = ~clk;

   cfg_port_reset_ctl u_cfg_port_reset_ctl (
      .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
      .io_dwaddr(io_dwaddr), .io_be(io_be), .io_wdata(io_wdata),
      .io_rvalid(io_rvalid), .io_rdata(io_rdata),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .cfg_func(cfg_func), .cfg_dword(cfg_dword), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sys_rst_req(sys_rst_req)
   );

   // downstream responder: a value derived from the selected location
   assign cfg_rdata = {cfg_bus, cfg_dev, cfg_func, cfg_dword, 2'b01, 8'hC3} ^ 32'h1234_0000;

   function automatic logic [31:0] resp_of(logic [31:0] s);
      return {s[23:16], s[15:11], s[10:8], s[7:2], 2'b01, 8'hC3} ^ 32'h1234_0000;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reset request compared on every clock
   always @(posedge clk) exp_rst <= rst_n ? pend_rst : 1'b0;
   always @(negedge clk) if (rst_n) check("R4 sys_rst_req", 32'(sys_rst_req), 32'(exp_rst));

   task automatic access(string req, bit wr, logic [15:0] port, logic [3:0] be,
                         logic [31:0] wd);
      int kind; // 0 none 1 addr 2 reset 3 data
      logic [31:0] exp_rd;
      logic exp_cfg;
      @(negedge clk);
      io_req = 1'b1; io_wr = wr; io_dwaddr = port[15:2]; io_be = be; io_wdata = wd;
      if (port[15:2] == 14'h33E && be == 4'b0010)      kind = 2;
      else if (port[15:2] == 14'h33E && be == 4'hF)    kind = 1;
      else if (port[15:2] == 14'h33F && be != 4'h0)    kind = 3;
      else                                             kind = 0;
      exp_cfg = (kind == 3) && m_sel[31];
      case (kind)
         1: exp_rd = m_sel;
         2: exp_rd = {22'd0, m_type, 9'd0};
         3: exp_rd = m_sel[31] ? resp_of(m_sel) : 32'hFFFF_FFFF;
         default: exp_rd = 32'hFFFF_FFFF;
      endcase
      pend_rst = wr && (kind == 2) && wd[10];
      #1;
      check({req, " cfg_req"}, 32'(cfg_req), 32'(exp_cfg));
      if (exp_cfg) begin
         check({req, " cfg fields"},
               {cfg_bus, cfg_dev, cfg_func, cfg_dword, 2'b00, 3'b0, cfg_we, cfg_be},
               {m_sel[23:2], 2'b00, 3'b0, wr, be});
         if (wr) check({req, " cfg_wdata"}, cfg_wdata, wd);
      end
      @(posedge clk);
      if (wr && kind == 1) m_sel = {wd[31:2], 2'b00};
      if (wr && kind == 2 && !wd[10]) m_type = wd[9];
      @(negedge clk);
      io_req = 1'b0; io_wr = 1'b0; io_be = '0; pend_rst = 1'b0;
      check({req, " io_rvalid"}, 32'(io_rvalid), 32'(!wr));
      if (!wr) check({req, " io_rdata"}, io_rdata, exp_rd);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_sel = '0; m_type = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 rvalid in reset", 32'(io_rvalid), 32'd0);
      check("R1 rst_req in reset", 32'(sys_rst_req), 32'd0);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      access("R1 addr read", 0, 16'hCF8, 4'hF, 0);
      access("R1 reset byte read", 0, 16'hCF9, 4'b0010, 0);
      access("R2 addr write", 1, 16'hCF8, 4'hF, 32'h8012_3A07);
      access("R2 addr read", 0, 16'hCF8, 4'hF, 0);
      access("R6 data read", 0, 16'hCFC, 4'hF, 0);
      access("R6 data write", 1, 16'hCFC, 4'b0101, 32'hDEAD_BEEF);
      access("R6 data byte read", 0, 16'hCFC, 4'b1000, 0);
      access("R5 type write", 1, 16'hCF9, 4'b0010, 32'hFFFF_02FF);
      access("R5 type read", 0, 16'hCF9, 4'b0010, 0);
      access("R3 addr after byte", 0, 16'hCF8, 4'hF, 0);
      access("R4 trigger write", 1, 16'hCF9, 4'b0010, 32'h0000_FF00);
      access("R4 type kept", 0, 16'hCF9, 4'b0010, 0);
      access("R5 clear type", 1, 16'hCF9, 4'b0010, 32'h0000_F900);
      access("R5 type cleared", 0, 16'hCF9, 4'b0010, 0);
      access("R4 trigger again", 1, 16'hCF9, 4'b0010, 32'h0000_0600);
      access("R4 type still 0", 0, 16'hCF9, 4'b0010, 0);
      access("R3 addr unchanged", 0, 16'hCF8, 4'hF, 0);
      access("R8 partial write", 1, 16'hCF8, 4'b0001, 32'h0000_00FF);
      access("R8 partial read", 0, 16'hCF8, 4'b0011, 0);
      access("R8 addr unchanged", 0, 16'hCF8, 4'hF, 0);
      access("R8 other port", 0, 16'h0080, 4'hF, 0);
      access("R8 other port write", 1, 16'h0CF0, 4'hF, 32'h1111_1111);
      access("R2 addr disable", 1, 16'hCF8, 4'hF, 32'h0001_0802);
      access("R7 disabled read", 0, 16'hCFC, 4'hF, 0);
      access("R7 disabled write", 1, 16'hCFC, 4'hF, 32'h5555_AAAA);
      access("R2 addr reenable", 1, 16'hCF8, 4'hF, 32'hFFFF_FFFF);
      access("R6 max selector read", 0, 16'hCFC, 4'b0110, 0);
      access("R5 set before reset", 1, 16'hCF9, 4'b0010, 32'h0000_0200);
      access("R5 set check", 0, 16'hCF9, 4'b0010, 0);
      do_reset();
      access("R1 reset byte after reset", 0, 16'hCF9, 4'b0010, 0);
      access("R1 addr after reset", 0, 16'hCF8, 4'hF, 0);
      access("R7 data after reset", 0, 16'hCFC, 4'hF, 0);
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule